// File: doc/BRIEF.md
# Compensated Real-Time-Clock Tick and Alarm Generator

This block turns a 32768 Hz enable strobe into a one-second tick for a calendar, applies a signed drift correction once per hour, and raises a periodic event pulse and an alarm pulse. A sub-second divider counts enable strobes. At the end of each second it emits `sec_tick` for one cycle. An hour counter, decremented on each tick, decides when the next second is trimmed. For that one second the divider length is changed by the signed compensation value, in units of one divider count.

Software writes a five-bit control word and the two bytes of the compensation value. A separate piece of logic converts the alarm time into a number of seconds and presents it on `alarm_secs` with a load strobe. The calendar supplies the current seconds, minutes and hours in binary for the periodic-event match. Calendar arithmetic and BCD encoding live outside this block.

The divider can be paused and resumed without losing the partial second. The alarm is a countdown of whole seconds that fires once when it expires.

Top module: `rtc_tick_alarm`

## Requirements
- R1: After reset `sec_tick`, `periodic_evt` and `alarm_evt` are 0, `ctrl_rd` reads 0 and `comp_rd` reads 0.
- R2: A `ctrl_we` write keeps `ctrl_wdata[4:0]`, which is visible on `ctrl_rd` in the following cycle. The bit assignments are: bit 0 run, bit 1 alarm enable, bit 2 twelve-hour mode (held only), and bits 4:3 the periodic select.
- R3: `comp_hi_we` loads `comp_wbyte` into compensation bits 15:8 and `comp_lo_we` loads it into bits 7:0. The other byte is left unchanged. The value is read as two's complement.
- R4: While run is set, every 2^SUB_W-th `en32k_i` strobe ends a second. `sec_tick` is high for the one cycle after the edge that counts that strobe.
- R5: The hour counter starts at HOUR_INIT and drops by one on each tick. The tick that takes it to zero reloads it to HOUR_TICKS, and the second that follows lasts 2^SUB_W minus the compensation value in strobes. That length is clamped to a minimum of 1.
- R6: While run is clear the partial second is frozen and no tick occurs. When run is set again, counting resumes from the strobes still remaining in that second.
- R7: `periodic_evt` pulses in the cycle after `sec_tick` when the match selected by bits 4:3 holds for the time inputs present while `sec_tick` is high. The matches are: 0 always, 1 `cur_sec`==0, 2 `cur_min`==0, 3 `cur_hour`==0.
- R8: The alarm countdown resets to ALARM_INIT. It is loaded from `alarm_secs` on an `alarm_load` pulse or a control write only if the resulting control word has both run and alarm enable set. Otherwise it is not loaded.
- R9: Each tick lowers a non-zero countdown by one. The tick that takes it from 1 to 0 while alarm enable is set causes a one-cycle `alarm_evt` in the following cycle. A countdown of 0 stays at 0 and never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en32k_i | input | 1 | 32768 Hz count enable strobe |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control write data (low five bits kept) |
| comp_hi_we | input | 1 | Write compensation high byte |
| comp_lo_we | input | 1 | Write compensation low byte |
| comp_wbyte | input | 8 | Compensation byte to write |
| alarm_load | input | 1 | Alarm time changed: reload countdown |
| alarm_secs | input | ALM_W | Seconds from now until the alarm |
| cur_sec | input | 6 | Current seconds (binary) |
| cur_min | input | 6 | Current minutes (binary) |
| cur_hour | input | 5 | Current hours (binary, 0-23) |
| ctrl_rd | output | 5 | Stored control word |
| comp_rd | output | 16 | Stored compensation value |
| sec_tick | output | 1 | One-second tick pulse |
| periodic_evt | output | 1 | Periodic event pulse |
| alarm_evt | output | 1 | Alarm event pulse |

## Verification
The bench goes after the trimmed second. It checks a positive correction, a negative one that lengthens the second, and a correction large enough to hit the one-strobe floor. A wrong sign or a missing clamp shows up as a wrong gap between ticks, or as a divider that wraps and goes silent. It also pauses the divider in mid-second: a design that reloads on resume delivers the next tick a full second late. The alarm is reloaded while running, so a countdown that ignores the reload, fires twice or fires one tick early produces a mismatch. A cycle model driven by constrained random writes, strobe gaps and time inputs also covers alarm loads that must be ignored and every periodic select.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;
    // Control word, bit 0 at the end of the list
    typedef struct packed {
        logic [1:0] period_sel;   // bits 4:3
        logic       mode12;       // bit 2
        logic       alarm_en;     // bit 1
        logic       run;          // bit 0
    } rtc_ctrl_t;

    typedef enum logic [1:0] {
        EV_EVERY    = 2'd0,
        EV_SEC_ZERO = 2'd1,
        EV_MIN_ZERO = 2'd2,
        EV_HR_ZERO  = 2'd3
    } ev_sel_e;
endpackage

// File: rtl/rtc_subsec_div.sv
module rtc_subsec_div #(
    parameter int SUB_W      = 15,
    parameter int HOUR_TICKS = 3600,
    parameter int HOUR_INIT  = 1800
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run_i,
    input  logic        en_i,
    input  logic [15:0] comp_i,
    output logic        tick_o
);
    localparam int PW = ((SUB_W + 2) > 17) ? (SUB_W + 2) : 17;
    localparam int HW = $clog2(HOUR_TICKS + 1);
    localparam logic [PW-1:0] PERIOD = {{(PW-1){1'b0}}, 1'b1} << SUB_W;

    typedef struct packed {
        logic [PW-1:0] remain;
        logic [HW-1:0] hour;
        logic          tick;
    } div_state_t;

    div_state_t st_d, st_q;
    logic signed [PW:0] trimmed;
    logic [PW-1:0]      trim_len;

    always_comb begin
        trimmed  = $signed({1'b0, PERIOD}) - $signed({{(PW+1-16){comp_i[15]}}, comp_i});
        trim_len = (trimmed[PW] || trimmed == '0) ? PW'(1) : trimmed[PW-1:0];

        st_d      = st_q;
        st_d.tick = 1'b0;
        if (run_i && en_i) begin
            if (st_q.remain == PW'(1)) begin
                st_d.tick = 1'b1;
                if (st_q.hour == HW'(1)) begin
                    st_d.hour   = HW'(HOUR_TICKS);
                    st_d.remain = trim_len;
                end else begin
                    st_d.hour   = st_q.hour - 1'b1;
                    st_d.remain = PERIOD;
                end
            end else begin
                st_d.remain = st_q.remain - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.remain <= PERIOD;
            st_q.hour   <= HW'(HOUR_INIT);
            st_q.tick   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;

    // R6: a stopped divider keeps its partial second
    assert_pause_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(st_q.remain));
    // R5: the divider never sits at zero, so a trimmed second cannot wrap
    assert_remain_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.remain != '0);
    // R5: the hour counter never reaches zero
    assert_hour_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hour != '0);
    // R4: a tick needs a counted strobe while running
    assert_tick_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tick |-> $past(run_i && en_i));
endmodule

// File: rtl/rtc_alarm_cnt.sv
module rtc_alarm_cnt #(
    parameter int ALM_W      = 20,
    parameter int ALARM_INIT = 1800
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             reload_i,
    input  logic [ALM_W-1:0] reload_val_i,
    input  logic             alm_en_i,
    output logic             evt_o
);
    typedef struct packed {
        logic [ALM_W-1:0] cnt;
        logic             evt;
    } alm_state_t;

    alm_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.evt = 1'b0;
        if (reload_i) begin
            st_d.cnt = reload_val_i;
        end else if (tick_i) begin
            if (st_q.cnt == ALM_W'(1) && alm_en_i) st_d.evt = 1'b1;
            if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= ALM_W'(ALARM_INIT);
            st_q.evt <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o = st_q.evt;

    // R9: an alarm pulse follows a tick taken with the alarm enabled
    assert_alarm_after_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.evt |-> ($past(tick_i) && $past(alm_en_i)));
    // R9: the pulse lasts one cycle
    assert_alarm_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.evt |=> !st_q.evt);
    // R8: a reload lands the presented value
    assert_reload_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> st_q.cnt == $past(reload_val_i));
endmodule

// File: rtl/rtc_period_sel.sv
module rtc_period_sel
    import rtc_tick_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  ev_sel_e    sel_i,
    input  logic [5:0] sec_i,
    input  logic [5:0] min_i,
    input  logic [4:0] hour_i,
    output logic       evt_o
);
    logic evt_d, evt_q;
    logic hit;

    always_comb begin
        unique case (sel_i)
            EV_EVERY:    hit = 1'b1;
            EV_SEC_ZERO: hit = (sec_i == '0);
            EV_MIN_ZERO: hit = (min_i == '0);
            default:     hit = (hour_i == '0);
        endcase
        evt_d = tick_i && hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= 1'b0;
        else        evt_q <= evt_d;
    end

    assign evt_o = evt_q;

    // R7: a periodic pulse only ever follows a tick
    assert_periodic_after_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |-> $past(tick_i));
    // R7: the every-second select never skips a tick
    assert_every_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && sel_i == EV_EVERY) |=> evt_q);
endmodule

// File: rtl/rtc_tick_alarm.sv
module rtc_tick_alarm
    import rtc_tick_pkg::*;
#(
    parameter int SUB_W      = 15,
    parameter int HOUR_TICKS = 3600,
    parameter int HOUR_INIT  = 1800,
    parameter int ALARM_INIT = 1800,
    parameter int ALM_W      = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en32k_i,
    input  logic             ctrl_we,
    input  logic [7:0]       ctrl_wdata,
    input  logic             comp_hi_we,
    input  logic             comp_lo_we,
    input  logic [7:0]       comp_wbyte,
    input  logic             alarm_load,
    input  logic [ALM_W-1:0] alarm_secs,
    input  logic [5:0]       cur_sec,
    input  logic [5:0]       cur_min,
    input  logic [4:0]       cur_hour,
    output logic [4:0]       ctrl_rd,
    output logic [15:0]      comp_rd,
    output logic             sec_tick,
    output logic             periodic_evt,
    output logic             alarm_evt
);
    typedef struct packed {
        rtc_ctrl_t   ctrl;
        logic [15:0] comp;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  reload;

    always_comb begin
        regs_d = regs_q;
        if (ctrl_we)    regs_d.ctrl       = rtc_ctrl_t'(ctrl_wdata[4:0]);
        if (comp_hi_we) regs_d.comp[15:8] = comp_wbyte;
        if (comp_lo_we) regs_d.comp[7:0]  = comp_wbyte;
        // the reload looks at the control word as it stands after this write
        reload = (ctrl_we || alarm_load) && regs_d.ctrl.run && regs_d.ctrl.alarm_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    rtc_subsec_div #(
        .SUB_W     (SUB_W),
        .HOUR_TICKS(HOUR_TICKS),
        .HOUR_INIT (HOUR_INIT)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (regs_q.ctrl.run),
        .en_i  (en32k_i),
        .comp_i(regs_q.comp),
        .tick_o(sec_tick)
    );

    rtc_alarm_cnt #(
        .ALM_W     (ALM_W),
        .ALARM_INIT(ALARM_INIT)
    ) u_alarm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (sec_tick),
        .reload_i    (reload),
        .reload_val_i(alarm_secs),
        .alm_en_i    (regs_q.ctrl.alarm_en),
        .evt_o       (alarm_evt)
    );

    rtc_period_sel u_period (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_i(sec_tick),
        .sel_i (ev_sel_e'(regs_q.ctrl.period_sel)),
        .sec_i (cur_sec),
        .min_i (cur_min),
        .hour_i(cur_hour),
        .evt_o (periodic_evt)
    );

    assign ctrl_rd = regs_q.ctrl;
    assign comp_rd = regs_q.comp;

    // R2: a control write is visible on the readback one cycle later
    assert_ctrl_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> ctrl_rd == $past(ctrl_wdata[4:0]));
    // R3: a high-byte-only write leaves the low byte alone
    assert_comp_lo_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_hi_we && !comp_lo_we) |=> comp_rd[7:0] == $past(comp_rd[7:0]));
endmodule

// File: tb/rtc_tick_alarm_tb.sv
module rtc_tick_alarm_tb;
    localparam int SUB_W      = 3;
    localparam int PER        = 1 << SUB_W;
    localparam int HOUR_TICKS = 5;
    localparam int HOUR_INIT  = 3;
    localparam int ALARM_INIT = 6;
    localparam int ALM_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en32k_i = 1'b0;
    logic             ctrl_we = 1'b0;
    logic [7:0]       ctrl_wdata = '0;
    logic             comp_hi_we = 1'b0;
    logic             comp_lo_we = 1'b0;
    logic [7:0]       comp_wbyte = '0;
    logic             alarm_load = 1'b0;
    logic [ALM_W-1:0] alarm_secs = '0;
    logic [5:0]       cur_sec = 6'd7;
    logic [5:0]       cur_min = 6'd7;
    logic [4:0]       cur_hour = 5'd7;
    logic [4:0]       ctrl_rd;
    logic [15:0]      comp_rd;
    logic             sec_tick, periodic_evt, alarm_evt;

    rtc_tick_alarm #(
        .SUB_W(SUB_W), .HOUR_TICKS(HOUR_TICKS), .HOUR_INIT(HOUR_INIT),
        .ALARM_INIT(ALARM_INIT), .ALM_W(ALM_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .en32k_i(en32k_i),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .comp_hi_we(comp_hi_we), .comp_lo_we(comp_lo_we), .comp_wbyte(comp_wbyte),
        .alarm_load(alarm_load), .alarm_secs(alarm_secs),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .ctrl_rd(ctrl_rd), .comp_rd(comp_rd),
        .sec_tick(sec_tick), .periodic_evt(periodic_evt), .alarm_evt(alarm_evt)
    );

    always #10 clk = ~clk;   // 50 MHz

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 0;
    bit model_on = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int trim_len(input logic [15:0] c);
        int t;
        t = PER - int'($signed(c));
        return (t < 1) ? 1 : t;
    endfunction

    function automatic bit per_match(input logic [1:0] sel, input int s, input int m, input int h);
        case (sel)
            2'd0: return 1'b1;
            2'd1: return s == 0;
            2'd2: return m == 0;
            default: return h == 0;
        endcase
    endfunction

    // reference model built from the requirements
    logic [4:0]  mc;
    logic [15:0] mcomp;
    int mrem, mhr, mcnt;
    bit m_tick, m_per, m_alm;

    always @(posedge clk) begin
        if (!rst_n) begin
            mc = '0; mcomp = '0; mrem = PER; mhr = HOUR_INIT; mcnt = ALARM_INIT;
            m_tick = 0; m_per = 0; m_alm = 0;
        end else begin : mdl
            logic [4:0] nc;
            bit nt, np, na;
            nc = ctrl_we ? ctrl_wdata[4:0] : mc;
            nt = 0;
            if (mc[0] && en32k_i) begin
                if (mrem == 1) begin
                    nt = 1;
                    if (mhr == 1) begin mhr = HOUR_TICKS; mrem = trim_len(mcomp); end
                    else begin mhr--; mrem = PER; end
                end else mrem--;
            end
            np = m_tick && per_match(mc[4:3], cur_sec, cur_min, cur_hour);
            na = 0;
            if ((ctrl_we || alarm_load) && nc[0] && nc[1]) mcnt = alarm_secs;
            else if (m_tick) begin
                na = (mcnt == 1) && mc[1];
                if (mcnt != 0) mcnt--;
            end
            if (comp_hi_we) mcomp[15:8] = comp_wbyte;
            if (comp_lo_we) mcomp[7:0]  = comp_wbyte;
            mc = nc; m_tick = nt; m_per = np; m_alm = na;
        end
    end

    // event logger and model comparison, away from the active edge
    int tick_cnt = 0, per_cnt = 0, alm_cnt = 0, last_tick = 0;
    int gaps[16];

    always @(negedge clk) begin
        if (rst_n) begin
            if (sec_tick) begin
                if (tick_cnt < 16) gaps[tick_cnt] = cyc - last_tick;
                last_tick = cyc;
                tick_cnt++;
            end
            if (periodic_evt) per_cnt++;
            if (alarm_evt) alm_cnt++;
            if (model_on) begin
                chk(sec_tick == m_tick, "R4 sec_tick vs model", sec_tick, m_tick);
                chk(periodic_evt == m_per, "R7 periodic_evt vs model", periodic_evt, m_per);
                chk(alarm_evt == m_alm, "R9 alarm_evt vs model", alarm_evt, m_alm);
                chk(ctrl_rd == mc, "R2 ctrl_rd vs model", ctrl_rd, mc);
                chk(comp_rd == mcomp, "R3 comp_rd vs model", comp_rd, mcomp);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; en32k_i = 0; ctrl_we = 0; comp_hi_we = 0; comp_lo_we = 0;
        alarm_load = 0; alarm_secs = '0; cur_sec = 6'd7; cur_min = 6'd7; cur_hour = 5'd7;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(posedge clk);
        tick_cnt = 0; per_cnt = 0; alm_cnt = 0; last_tick = cyc;
        @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        ctrl_wdata = v; ctrl_we = 1;
        @(negedge clk);
        ctrl_we = 0;
    endtask

    task automatic wr_comp(input logic [7:0] hi, input logic [7:0] lo);
        comp_wbyte = hi; comp_hi_we = 1;
        @(negedge clk);
        comp_hi_we = 0; comp_wbyte = lo; comp_lo_we = 1;
        @(negedge clk);
        comp_lo_we = 0;
    endtask

    task automatic wait_ticks(input int n);
        int target;
        target = tick_cnt + n;
        while (tick_cnt < target) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic clr_counts();
        @(posedge clk);
        per_cnt = 0; alm_cnt = 0;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_on = 1;

        // R1: reset state
        do_reset();
        chk(sec_tick == 0, "R1 sec_tick", sec_tick, 0);
        chk(periodic_evt == 0, "R1 periodic_evt", periodic_evt, 0);
        chk(alarm_evt == 0, "R1 alarm_evt", alarm_evt, 0);
        chk(ctrl_rd == 0, "R1 ctrl_rd", ctrl_rd, 0);
        chk(comp_rd == 0, "R1 comp_rd", comp_rd, 0);

        // R2 / R3: register readback
        wr_ctrl(8'hEE);
        chk(ctrl_rd == 5'h0E, "R2 ctrl keeps low five bits", ctrl_rd, 5'h0E);
        wr_comp(8'hFF, 8'hFE);
        chk(comp_rd == 16'hFFFE, "R3 comp both bytes", comp_rd, 16'hFFFE);
        comp_wbyte = 8'h03; comp_lo_we = 1; @(negedge clk); comp_lo_we = 0;
        chk(comp_rd == 16'hFF03, "R3 low byte only", comp_rd, 16'hFF03);

        // R4 / R5: positive trim shortens the second after HOUR_INIT ticks
        do_reset();
        wr_comp(8'h00, 8'h03);
        en32k_i = 1;
        wr_ctrl(8'h01);
        wait_ticks(9);
        chk(gaps[2] == PER, "R4 plain second length", gaps[2], PER);
        chk(gaps[3] == PER - 3, "R5 trimmed second", gaps[3], PER - 3);
        chk(gaps[4] == PER, "R5 back to nominal", gaps[4], PER);
        chk(gaps[8] == PER - 3, "R5 trim after hour reload", gaps[8], PER - 3);

        // R5: negative trim lengthens
        do_reset();
        wr_comp(8'hFF, 8'hFC);
        en32k_i = 1;
        wr_ctrl(8'h01);
        wait_ticks(5);
        chk(gaps[3] == PER + 4, "R5 negative trim", gaps[3], PER + 4);

        // R5: clamp to one strobe
        do_reset();
        wr_comp(8'h00, 8'h64);
        en32k_i = 1;
        wr_ctrl(8'h01);
        wait_ticks(5);
        chk(gaps[3] == 1, "R5 clamp to one", gaps[3], 1);
        chk(gaps[4] == PER, "R5 after clamp", gaps[4], PER);

        // R6: pause keeps the partial second
        do_reset();
        en32k_i = 1;
        wr_ctrl(8'h01);
        repeat (3) @(negedge clk);
        wr_ctrl(8'h00);
        repeat (20) @(negedge clk);
        chk(tick_cnt == 0, "R6 no tick while paused", tick_cnt, 0);
        wr_ctrl(8'h01);
        begin
            int k;
            k = 0;
            while (!sec_tick && k < 40) begin @(negedge clk); k++; end
            chk(k == 4, "R6 resume from remaining count", k, 4);
        end

        // R7: periodic selects
        do_reset();
        en32k_i = 1;
        wr_ctrl(8'h01);
        wait_ticks(3);
        chk(per_cnt == 3, "R7 select 0 every tick", per_cnt, 3);
        cur_min = 6'd1;
        wr_ctrl(8'h11);
        clr_counts();
        wait_ticks(2);
        chk(per_cnt == 0, "R7 select 2 minutes nonzero", per_cnt, 0);
        cur_min = 6'd0;
        clr_counts();
        wait_ticks(2);
        chk(per_cnt == 2, "R7 select 2 minutes zero", per_cnt, 2);
        cur_sec = 6'd0; cur_hour = 5'd4;
        wr_ctrl(8'h19);
        clr_counts();
        wait_ticks(2);
        chk(per_cnt == 0, "R7 select 3 hours nonzero", per_cnt, 0);

        // R8 / R9: alarm countdown and reload
        do_reset();
        en32k_i = 1;
        alarm_secs = 8'd2;
        wr_ctrl(8'h03);
        wait_ticks(1);
        chk(alm_cnt == 0, "R9 no alarm before expiry", alm_cnt, 0);
        wait_ticks(1);
        chk(alm_cnt == 1, "R9 alarm on expiry", alm_cnt, 1);
        wait_ticks(2);
        chk(alm_cnt == 1, "R9 countdown holds at zero", alm_cnt, 1);
        alarm_secs = 8'd3; alarm_load = 1; @(negedge clk); alarm_load = 0;
        clr_counts();
        wait_ticks(2);
        chk(alm_cnt == 0, "R8 reloaded countdown not yet due", alm_cnt, 0);
        wait_ticks(1);
        chk(alm_cnt == 1, "R8 reloaded countdown fires", alm_cnt, 1);

        // constrained random against the model (R2 R3 R4 R5 R6 R7 R8 R9)
        do_reset();
        wr_comp(8'h00, 8'h02);
        for (int i = 0; i < 30000; i++) begin
            en32k_i    = ($urandom % 4) != 0;
            ctrl_we    = ($urandom % 150) == 0;
            ctrl_wdata = 8'($urandom);
            if (($urandom % 4) != 0) ctrl_wdata[0] = 1'b1;
            alarm_load = ($urandom % 60) == 0;
            alarm_secs = ALM_W'($urandom % 6);
            comp_hi_we = ($urandom % 400) == 0;
            comp_lo_we = ($urandom % 400) == 0;
            comp_wbyte = comp_hi_we ? ((($urandom % 2) != 0) ? 8'hFF : 8'h00) : 8'($urandom % 24);
            if (comp_hi_we && comp_lo_we) comp_lo_we = 0;
            cur_sec  = 6'($urandom % 2);
            cur_min  = 6'($urandom % 2);
            cur_hour = 5'($urandom % 2);
            @(negedge clk);
        end
        ctrl_we = 0; alarm_load = 0; comp_hi_we = 0; comp_lo_we = 0;
        repeat (4) @(negedge clk);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule